// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Occupancy Flags

This block is a first-in first-out buffer whose producer and consumer run on unrelated clocks. A write port pushes words on the write clock, and a read port pops them on the read clock. Three active-low status outputs sit beside the usual empty and full indications. An almost-full flag asserts when free space falls to a chosen margin. An almost-empty flag asserts when only a few words remain. A half-full flag asserts once more than half the storage is occupied.

The configuration inputs are sampled on every clock edge while the active-low reset is held. Two output styles are available. In the plain style, a read request loads the next word into a registered output. In the look-ahead style, a one-word output stage presents the oldest word before it is requested, so capacity grows by one word and every threshold moves up by one. Each programmable flag can be timed in one of two ways. In the single-domain way, it is a register clocked only by its own side's clock. In the split way, it reacts to writes at once on the write edge and to reads at once on the read edge. The half-full flag always uses the split way.

The read side holds a two-state machine. State OS_IDLE means no word is held in the output stage. State OS_HOLD means a word is presented. The machine has three transitions: OS_IDLE→OS_HOLD (look-ahead style, memory not empty), OS_HOLD→OS_IDLE (read taken while memory is empty), and OS_HOLD→OS_HOLD (read taken with memory refilling, or no read). In the plain style, the machine stays in OS_IDLE.

Top module: `prog_flag_fifo`

## Requirements
- R1: After reset, with no traffic, full_n=1, empty_n=0, paf_n=1, hf_n=1 and pae_n=0.
- R2: In plain style (cfg_fwft=0), a read-clock edge with rd_en=1 and empty_n=1 loads the oldest stored word into rd_data; words come out in write order.
- R3: In look-ahead style (cfg_fwft=1), the oldest word appears on rd_data with empty_n=1 and no rd_en; each read taken replaces it with the next word, and rd_data holds while rd_en=0.
- R4: full_n goes low when D words are stored in plain style, or D+1 in look-ahead style. A write while full_n=0 is dropped, and a read while empty_n=0 leaves rd_data unchanged.
- R5: paf_n is low when the occupancy is at least D-m (plain) or D+1-m (look-ahead), with m = cfg_full_off.
- R6: pae_n is low when the occupancy is at most n (plain) or n+1 (look-ahead), with n = cfg_empty_off.
- R7: hf_n is low when the occupancy exceeds D/2 (plain) or D/2+1 (look-ahead).
- R8: With cfg_paf_async=0, paf_n changes only on write-clock edges; a read lowers the occupancy but lets paf_n rise only after later write-clock edges.
- R9: With cfg_paf_async=1, paf_n falls right after the write edge that reaches the threshold and rises right after the read edge that leaves it.
- R10: With cfg_pae_async=0, pae_n changes only on read-clock edges; a write that lifts the occupancy above n lets pae_n rise only after later read-clock edges.
- R11: With cfg_pae_async=1, pae_n rises right after the write edge that leaves the threshold and falls right after the read edge that reaches it.
- R12: hf_n falls right after the write edge that crosses half depth and rises right after the read edge that returns to half depth.
- R13: With cfg_use_default=1 during reset, both offsets take the value 7, whatever cfg_full_off and cfg_empty_off carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset; configuration is sampled while it is low |
| cfg_fwft | input | 1 | 1 selects the look-ahead output style |
| cfg_paf_async | input | 1 | 1 selects split timing for paf_n |
| cfg_pae_async | input | 1 | 1 selects split timing for pae_n |
| cfg_use_default | input | 1 | 1 replaces both offsets with 7 |
| cfg_full_off | input | AW | Almost-full offset m |
| cfg_empty_off | input | AW | Almost-empty offset n |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write word |
| full_n | output | 1 | Low when full |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Read word |
| empty_n | output | 1 | Low when no word is available |
| paf_n | output | 1 | Almost-full flag, active low |
| pae_n | output | 1 | Almost-empty flag, active low |
| hf_n | output | 1 | Half-full flag, active low |

## Verification
A pointer that drifts from the true word count shows at the flag pins within a few cycles: a threshold crossing lands one word early or late. The same drift makes full_n and empty_n disagree with the number of words actually pushed. A corrupted output-stage state shows on the next read, either as a word that is skipped or repeated, or as empty_n staying high after the last word is taken. Wrong synchronisation is exposed by sampling one nanosecond after single edges. In the single-domain timing, the flag must still hold its old value at that point. In the split timing, it must already have moved.

// File: rtl/pff_pkg.sv
`timescale 1ns/1ps
package pff_pkg;
    // Output stage of the read side
    typedef enum logic {
        OS_IDLE = 1'b0,
        OS_HOLD = 1'b1
    } os_state_e;
endpackage

// File: rtl/pff_ptr_sync.sv
`timescale 1ns/1ps
module pff_ptr_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stg1, stg2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg1 <= '0;
            stg2 <= '0;
        end else begin
            stg1 <= gray_in;
            stg2 <= stg1;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_g2b
        assign bin_out[i] = ^stg2[W-1:i];
    end
endmodule

// File: rtl/pff_wr_side.sv
`timescale 1ns/1ps
module pff_wr_side #(
    parameter int DW = 18,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [AW:0]   rcore_s,
    input  logic [AW:0]   ruser_s,
    input  logic [AW:0]   paf_thr,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] mem_q,
    output logic          full_n,
    output logic          paf_q,
    output logic [AW:0]   wptr,
    output logic [AW:0]   wptr_gray
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW:0]   core_cnt, wptr_nx, cnt_nx;
    logic          do_wr;

    assign core_cnt = wptr - rcore_s;
    assign full_n   = (core_cnt != DEPTH_V);
    assign do_wr    = wr_en && full_n;
    assign wptr_nx  = wptr + {{AW{1'b0}}, do_wr};
    assign cnt_nx   = wptr_nx - ruser_s;
    assign mem_q    = mem[raddr];

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr      <= '0;
            wptr_gray <= '0;
            paf_q     <= 1'b1;
        end else begin
            wptr      <= wptr_nx;
            wptr_gray <= wptr_nx ^ (wptr_nx >> 1);
            paf_q     <= !(cnt_nx >= paf_thr);
        end
    end

    always_ff @(posedge wr_clk) begin
        if (do_wr) mem[wptr[AW-1:0]] <= wr_data;
    end
endmodule

// File: rtl/pff_rd_side.sv
`timescale 1ns/1ps
module pff_rd_side
    import pff_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 4
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          fwft,
    input  logic [AW:0]   wptr_s,
    input  logic [AW:0]   pae_thr,
    input  logic [DW-1:0] mem_q,
    output logic [AW-1:0] raddr,
    output logic [DW-1:0] rd_data,
    output logic          empty_n,
    output logic          pae_q,
    output logic [AW:0]   ruser,
    output logic [AW:0]   rcore_gray,
    output logic [AW:0]   ruser_gray
);
    os_state_e   state, state_nx;
    logic [AW:0] rcore, rcore_nx, ruser_nx, cnt_nx;
    logic        core_empty, load, pop;

    assign core_empty = (rcore == wptr_s);
    assign raddr      = rcore[AW-1:0];

    // State register
    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) state <= OS_IDLE;
        else        state <= state_nx;
    end

    // Next state and stage controls
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        pop      = 1'b0;
        unique case (state)
            OS_IDLE: begin
                if (!fwft) begin
                    if (rd_en && !core_empty) begin
                        load = 1'b1;
                        pop  = 1'b1;
                    end
                end else if (!core_empty) begin
                    load     = 1'b1;
                    state_nx = OS_HOLD;
                end
            end
            OS_HOLD: begin
                if (rd_en) begin
                    pop = 1'b1;
                    if (!core_empty) load = 1'b1;
                    else             state_nx = OS_IDLE;
                end
            end
        endcase
    end

    assign rcore_nx = rcore + {{AW{1'b0}}, load};
    assign ruser_nx = ruser + {{AW{1'b0}}, pop};
    assign cnt_nx   = wptr_s - ruser_nx;
    assign empty_n  = fwft ? (state == OS_HOLD) : !core_empty;

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rcore      <= '0;
            ruser      <= '0;
            rcore_gray <= '0;
            ruser_gray <= '0;
            rd_data    <= '0;
            pae_q      <= 1'b0;
        end else begin
            rcore      <= rcore_nx;
            ruser      <= ruser_nx;
            rcore_gray <= rcore_nx ^ (rcore_nx >> 1);
            ruser_gray <= ruser_nx ^ (ruser_nx >> 1);
            if (load) rd_data <= mem_q;
            pae_q      <= !(cnt_nx <= pae_thr);
        end
    end
endmodule

// File: rtl/prog_flag_fifo.sv
`timescale 1ns/1ps
module prog_flag_fifo #(
    parameter int DW      = 18,
    parameter int AW      = 4,
    parameter int DEF_OFF = 7
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          cfg_fwft,
    input  logic          cfg_paf_async,
    input  logic          cfg_pae_async,
    input  logic          cfg_use_default,
    input  logic [AW-1:0] cfg_full_off,
    input  logic [AW-1:0] cfg_empty_off,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          full_n,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty_n,
    output logic          paf_n,
    output logic          pae_n,
    output logic          hf_n
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);
    localparam logic [AW:0] HALF_V  = (AW+1)'(DEPTH / 2);

    // Configuration sampled in each domain while reset is held
    logic          fwft_w, paf_async_w, fwft_r, pae_async_r;
    logic [AW-1:0] m_w, n_r;

    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            fwft_w      <= cfg_fwft;
            paf_async_w <= cfg_paf_async;
            m_w         <= cfg_use_default ? AW'(DEF_OFF) : cfg_full_off;
        end
    end

    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            fwft_r      <= cfg_fwft;
            pae_async_r <= cfg_pae_async;
            n_r         <= cfg_use_default ? AW'(DEF_OFF) : cfg_empty_off;
        end
    end

    logic [AW:0]   paf_thr, pae_thr, hf_thr;
    logic [AW:0]   w_ptr, w_gray, w_ptr_s;
    logic [AW:0]   r_user, r_core_gray, r_user_gray, r_core_s, r_user_s;
    logic [AW:0]   occ_x;
    logic [AW-1:0] raddr;
    logic [DW-1:0] mem_q;
    logic          paf_q, pae_q;

    assign paf_thr = DEPTH_V + {{AW{1'b0}}, fwft_w} - {1'b0, m_w};
    assign pae_thr = {1'b0, n_r} + {{AW{1'b0}}, fwft_r};
    assign hf_thr  = HALF_V + {{AW{1'b0}}, fwft_w};

    pff_wr_side #(.DW(DW), .AW(AW)) u_wr (
        .wr_clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rcore_s(r_core_s), .ruser_s(r_user_s), .paf_thr(paf_thr),
        .raddr(raddr), .mem_q(mem_q), .full_n(full_n), .paf_q(paf_q),
        .wptr(w_ptr), .wptr_gray(w_gray)
    );

    pff_rd_side #(.DW(DW), .AW(AW)) u_rd (
        .rd_clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .fwft(fwft_r),
        .wptr_s(w_ptr_s), .pae_thr(pae_thr), .mem_q(mem_q), .raddr(raddr),
        .rd_data(rd_data), .empty_n(empty_n), .pae_q(pae_q), .ruser(r_user),
        .rcore_gray(r_core_gray), .ruser_gray(r_user_gray)
    );

    pff_ptr_sync #(.W(AW+1)) u_sync_w2r (
        .clk(rd_clk), .rst_n(rst_n), .gray_in(w_gray), .bin_out(w_ptr_s)
    );
    pff_ptr_sync #(.W(AW+1)) u_sync_core (
        .clk(wr_clk), .rst_n(rst_n), .gray_in(r_core_gray), .bin_out(r_core_s)
    );
    pff_ptr_sync #(.W(AW+1)) u_sync_user (
        .clk(wr_clk), .rst_n(rst_n), .gray_in(r_user_gray), .bin_out(r_user_s)
    );

    // Split-timing flags: compare the two local pointers directly
    assign occ_x = w_ptr - r_user;
    assign paf_n = paf_async_w ? !(occ_x >= paf_thr) : paf_q;
    assign pae_n = pae_async_r ? !(occ_x <= pae_thr) : pae_q;
    assign hf_n  = !(occ_x > hf_thr);
endmodule

// File: rtl/pff_checker.sv
`timescale 1ns/1ps
module pff_checker #(
    parameter int DW = 18,
    parameter int AW = 4
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          full_n,
    input logic          empty_n,
    input logic          fwft,
    input logic [DW-1:0] rd_data,
    input logic [AW:0]   wptr,
    input logic [AW:0]   ruser
);
    logic [AW:0] occ, occ_max;
    assign occ     = wptr - ruser;
    assign occ_max = (AW+1)'(1 << AW) + {{AW{1'b0}}, fwft};

    AST_FULL_DROPS_WRITE: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!full_n && wr_en) |=> $stable(wptr)); // R4

    AST_EMPTY_KEEPS_DATA: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!fwft && !empty_n && rd_en) |=> $stable(rd_data)); // R4

    AST_STAGE_HOLDS: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (fwft && empty_n && !rd_en) |=> (empty_n && $stable(rd_data))); // R3

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
        occ <= occ_max); // R4
endmodule

bind prog_flag_fifo pff_checker #(.DW(DW), .AW(AW)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en),
    .rd_en(rd_en), .full_n(full_n), .empty_n(empty_n), .fwft(fwft_r),
    .rd_data(rd_data), .wptr(w_ptr), .ruser(r_user)
);

// File: tb/tb_prog_flag_fifo.sv
`timescale 1ns/1ps
module tb_prog_flag_fifo;
    localparam int DW = 18;
    localparam int AW = 4;

    logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic cfg_fwft = 1'b0, cfg_paf_async = 1'b0, cfg_pae_async = 1'b0, cfg_use_default = 1'b0;
    logic [AW-1:0] cfg_full_off = '0, cfg_empty_off = '0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic full_n, empty_n, paf_n, pae_n, hf_n;

    int checks = 0;
    int errors = 0;

    prog_flag_fifo #(.DW(DW), .AW(AW)) dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .cfg_fwft(cfg_fwft), .cfg_paf_async(cfg_paf_async), .cfg_pae_async(cfg_pae_async),
        .cfg_use_default(cfg_use_default), .cfg_full_off(cfg_full_off),
        .cfg_empty_off(cfg_empty_off), .wr_en(wr_en), .wr_data(wr_data),
        .full_n(full_n), .rd_en(rd_en), .rd_data(rd_data), .empty_n(empty_n),
        .paf_n(paf_n), .pae_n(pae_n), .hf_n(hf_n)
    );

    initial forever #2.5 wr_clk = ~wr_clk;
    initial begin
        #1.25;
        forever #2.5 rd_clk = ~rd_clk;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // fwft, async flags, m, n, writes, reads, expected paf_n, pae_n, hf_n, full_n
    typedef struct packed {
        logic       fwft;
        logic       asy;
        logic [3:0] m;
        logic [3:0] n;
        logic [4:0] nw;
        logic [4:0] nr;
        logic       paf;
        logic       pae;
        logic       hf;
        logic       full;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{1'b0, 1'b0, 4'd7, 4'd7, 5'd9,  5'd0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{1'b0, 1'b1, 4'd7, 4'd7, 5'd8,  5'd0, 1'b1, 1'b1, 1'b1, 1'b1},
        '{1'b0, 1'b0, 4'd7, 4'd7, 5'd7,  5'd0, 1'b1, 1'b0, 1'b1, 1'b1},
        '{1'b0, 1'b1, 4'd3, 4'd2, 5'd13, 5'd0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{1'b0, 1'b0, 4'd3, 4'd2, 5'd12, 5'd0, 1'b1, 1'b1, 1'b0, 1'b1},
        '{1'b0, 1'b1, 4'd7, 4'd7, 5'd16, 5'd7, 1'b0, 1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b0, 4'd7, 4'd7, 5'd10, 5'd0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b1, 4'd7, 4'd7, 5'd9,  5'd0, 1'b1, 1'b1, 1'b1, 1'b1},
        '{1'b1, 1'b0, 4'd7, 4'd7, 5'd8,  5'd0, 1'b1, 1'b0, 1'b1, 1'b1},
        '{1'b1, 1'b1, 4'd7, 4'd7, 5'd17, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b0, 4'd7, 4'd7, 5'd16, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b1, 4'd2, 4'd4, 5'd12, 5'd3, 1'b1, 1'b1, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic fw, input logic pa, input logic pe,
                            input logic [AW-1:0] m, input logic [AW-1:0] n, input logic dflt);
        @(negedge wr_clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        cfg_fwft = fw; cfg_paf_async = pa; cfg_pae_async = pe;
        cfg_full_off = m; cfg_empty_off = n; cfg_use_default = dflt;
        repeat (4) @(negedge wr_clk);
        rst_n = 1'b1;
        repeat (4) @(negedge wr_clk);
    endtask

    task automatic wr_n(input int cnt, input int base);
        if (cnt > 0) begin
            @(negedge wr_clk);
            for (int i = 0; i < cnt; i++) begin
                wr_en = 1'b1;
                wr_data = DW'(base + i);
                @(negedge wr_clk);
            end
            wr_en = 1'b0;
        end
    endtask

    task automatic rd_n(input int cnt);
        if (cnt > 0) begin
            @(negedge rd_clk);
            for (int i = 0; i < cnt; i++) begin
                rd_en = 1'b1;
                @(negedge rd_clk);
            end
            rd_en = 1'b0;
        end
    endtask

    task automatic rd_one();
        @(negedge rd_clk); rd_en = 1'b1;
        @(negedge rd_clk); rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge wr_clk);
    endtask

    // One write; returns the flags sampled 1 ns after that write edge
    task automatic wr_edge(input int val, output logic paf_s, output logic pae_s, output logic hf_s);
        @(negedge wr_clk); wr_en = 1'b1; wr_data = DW'(val);
        @(posedge wr_clk); #1;
        paf_s = paf_n; pae_s = pae_n; hf_s = hf_n;
        @(negedge wr_clk); wr_en = 1'b0;
    endtask

    // One read; returns the flags sampled 1 ns after that read edge
    task automatic rd_edge(output logic paf_s, output logic pae_s, output logic hf_s);
        @(negedge rd_clk); rd_en = 1'b1;
        @(posedge rd_clk); #1;
        paf_s = paf_n; pae_s = pae_n; hf_s = hf_n;
        @(negedge rd_clk); rd_en = 1'b0;
    endtask

    initial begin
        logic pf, pe, hf;
        int mism;

        // Table walk: R4 R5 R6 R7
        foreach (VECS[k]) begin
            do_reset(VECS[k].fwft, VECS[k].asy, VECS[k].asy, VECS[k].m, VECS[k].n, 1'b0);
            wr_n(int'(VECS[k].nw), 16'h40 + k);
            settle();
            rd_n(int'(VECS[k].nr));
            settle();
            chk("R5", $sformatf("vec%0d paf_n", k), 32'(paf_n), 32'(VECS[k].paf));
            chk("R6", $sformatf("vec%0d pae_n", k), 32'(pae_n), 32'(VECS[k].pae));
            chk("R7", $sformatf("vec%0d hf_n", k), 32'(hf_n), 32'(VECS[k].hf));
            chk("R4", $sformatf("vec%0d full_n", k), 32'(full_n), 32'(VECS[k].full));
        end

        // R1: reset state
        do_reset(1'b0, 1'b0, 1'b0, 4'd7, 4'd7, 1'b0);
        chk("R1", "full_n", 32'(full_n), 32'd1);
        chk("R1", "empty_n", 32'(empty_n), 32'd0);
        chk("R1", "paf_n", 32'(paf_n), 32'd1);
        chk("R1", "hf_n", 32'(hf_n), 32'd1);
        chk("R1", "pae_n", 32'(pae_n), 32'd0);

        // R2: plain-style order, then read while empty (R4)
        wr_n(3, 'h3A0);
        settle();
        chk("R2", "empty_n with data", 32'(empty_n), 32'd1);
        for (int i = 0; i < 3; i++) begin
            rd_one();
            chk("R2", $sformatf("word %0d", i), 32'(rd_data), 32'h3A0 + 32'(i));
        end
        settle();
        chk("R2", "empty_n after drain", 32'(empty_n), 32'd0);
        rd_one();
        chk("R4", "rd_data after empty read", 32'(rd_data), 32'h3A2);

        // R3: look-ahead style
        do_reset(1'b1, 1'b0, 1'b0, 4'd7, 4'd7, 1'b0);
        wr_n(2, 'h1111);
        settle();
        chk("R3", "empty_n before read", 32'(empty_n), 32'd1);
        chk("R3", "first word shown", 32'(rd_data), 32'h1111);
        rd_one();
        chk("R3", "second word shown", 32'(rd_data), 32'h1112);
        rd_one();
        settle();
        chk("R3", "empty_n after drain", 32'(empty_n), 32'd0);

        // R4: overflow dropped, order kept
        do_reset(1'b0, 1'b0, 1'b0, 4'd7, 4'd7, 1'b0);
        wr_n(16, 'h100);
        wr_n(3, 'h200);
        settle();
        chk("R4", "full_n at depth", 32'(full_n), 32'd0);
        mism = 0;
        for (int i = 0; i < 16; i++) begin
            rd_one();
            if (rd_data !== DW'('h100 + i)) mism++;
        end
        chk("R4", "order after dropped writes", 32'(mism), 32'd0);
        chk("R4", "last word", 32'(rd_data), 32'h10F);
        settle();
        chk("R4", "empty_n after 16 reads", 32'(empty_n), 32'd0);

        // R8: single-domain almost-full timing (m=7 -> threshold 9)
        do_reset(1'b0, 1'b0, 1'b0, 4'd7, 4'd7, 1'b0);
        wr_n(8, 0);
        settle();
        wr_edge(8, pf, pe, hf);
        chk("R8", "paf_n after 9th write edge", 32'(pf), 32'd0);
        settle();
        rd_edge(pf, pe, hf);
        chk("R8", "paf_n right after read edge", 32'(pf), 32'd0);
        settle();
        chk("R8", "paf_n after write edges", 32'(paf_n), 32'd1);

        // R9: split almost-full timing; R12 half-full in the same run
        do_reset(1'b0, 1'b1, 1'b0, 4'd7, 4'd7, 1'b0);
        wr_n(8, 0);
        settle();
        chk("R12", "hf_n at half", 32'(hf_n), 32'd1);
        wr_edge(8, pf, pe, hf);
        chk("R9", "paf_n after write edge", 32'(pf), 32'd0);
        chk("R12", "hf_n after write edge", 32'(hf), 32'd0);
        settle();
        rd_edge(pf, pe, hf);
        chk("R9", "paf_n after read edge", 32'(pf), 32'd1);
        chk("R12", "hf_n after read edge", 32'(hf), 32'd1);

        // R10: single-domain almost-empty timing (n=7)
        do_reset(1'b0, 1'b0, 1'b0, 4'd7, 4'd7, 1'b0);
        wr_n(7, 0);
        settle();
        wr_edge(7, pf, pe, hf);
        chk("R10", "pae_n right after write edge", 32'(pe), 32'd0);
        settle();
        chk("R10", "pae_n after read edges", 32'(pae_n), 32'd1);
        rd_edge(pf, pe, hf);
        chk("R10", "pae_n after read edge", 32'(pe), 32'd0);

        // R11: split almost-empty timing
        do_reset(1'b0, 1'b0, 1'b1, 4'd7, 4'd7, 1'b0);
        wr_n(7, 0);
        settle();
        wr_edge(7, pf, pe, hf);
        chk("R11", "pae_n after write edge", 32'(pe), 32'd1);
        settle();
        rd_edge(pf, pe, hf);
        chk("R11", "pae_n after read edge", 32'(pe), 32'd0);

        // R13: default offsets override the inputs (inputs say 2)
        do_reset(1'b0, 1'b0, 1'b0, 4'd2, 4'd2, 1'b1);
        wr_n(7, 0);
        settle();
        chk("R13", "pae_n at 7 words", 32'(pae_n), 32'd0);
        wr_n(2, 7);
        settle();
        chk("R13", "paf_n at 9 words", 32'(paf_n), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule